// File: doc/BRIEF.md
# Bit-Oriented Message Filter Receiver

This block sits on the receive data-link channel of a T1 extended-superframe framer. It watches the serial data-link bits and picks out 16-bit bit-oriented message codewords. Each codeword starts with a run of eight ones, followed by a zero, a 6-bit message code and a closing zero. In direct mode every valid codeword is passed to a receive FIFO write port as a code byte. In filter mode a code is passed on only after it has won a majority vote over the recent patterns. A status byte then marks the write as filtered data.

The receiver leaves message mode when it sees an HDLC opening flag or when software drops the receiver enable. In both cases it writes an end-of-frame status byte and pulses a message-end interrupt. In filter mode it also drops back to hunting when the accepted code is no longer seen, or when the channel goes idle. The FIFO storage and the HDLC frame receiver that takes over after a flag are separate blocks.

Top module: `bom_filter_rx`

## Requirements
- R1: A valid pattern is the 16 most recent sampled bits, first received first: eight ones, a zero, code bits c5..c0 (MSB first), then a zero. In direct mode (`filter_en_i`=0) each valid pattern writes byte {2'b00, code}. `wr_en_o` is high in the cycle after the clock edge that sampled the closing zero.
- R2: In filter mode (`filter_en_i`=1) a code is written only when it occurs in at least 7 of the last 10 valid patterns, counting the current one. The code write is followed in the next cycle by status byte 0x80.
- R3: After a code has been accepted in filter mode, further patterns carrying the same code write nothing.
- R4: After acceptance, 4 consecutive valid patterns that all differ from the accepted code clear the 10-pattern history and the accepted code. Only a new run of 7 of 10 can then write again.
- R5: In filter mode, 4 idle patterns clear the history and the accepted code. An idle pattern is each complete group of 16 consecutive ones. A valid pattern restarts the idle count.
- R6: The bit sequence 01111110, found at any bit offset, writes status byte 0x40 with `msg_end_o` high in the same cycle and clears the filter history. Sampling then stops until `rx_active_i` has been low and high again.
- R7: Dropping `rx_active_i` while sampling writes status byte 0x40 with `msg_end_o` high. Sampling starts on the second clock edge after `rx_active_i` goes high.
- R8: When a pattern's last eight bits also form a flag (code 0x3F), the pattern is treated as a valid code and not as a flag.
- R9: Bits with `bit_valid_i` low, and all bits while `rx_active_i` is low, have no effect.
- R10: After reset `wr_en_o` and `msg_end_o` are low.
- R11: Writes leave at most one per cycle, in the order code, 0x80 status, 0x40 end status, with no write lost when the events fall on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data-link bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for one cycle |
| rx_active_i | input | 1 | Receiver enable; its fall ends the message frame |
| filter_en_i | input | 1 | 1 = majority-filter mode, 0 = direct mode |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write byte: code or status |
| msg_end_o | output | 1 | Message-end interrupt pulse, coincides with the 0x40 write |

## Verification
The bench goes after the vote threshold with an interleaved pattern mix that reaches exactly 7 of 10 only on the tenth pattern. A receiver that counts one too many or too few writes a pattern early or never. It checks that the mismatch and idle exits really empty the history: a design that keeps stale entries writes again after fewer than seven fresh patterns. The all-ones code, whose tail looks like a flag, must come out as data and not end the frame. A deactivation on the cycle right after an acceptance must still produce code, filtered status and end status in that order, which a single-slot output stage would lose. A long run of random filtered traffic with bit gaps is compared against a bench model of the vote.

// File: rtl/bom_rx_pkg.sv
package bom_rx_pkg;
  localparam int CODE_W = 6;
  localparam logic [7:0] ST_FILTERED = 8'h80;
  localparam logic [7:0] ST_FRAME_END = 8'h40;
  localparam logic [7:0] HDLC_FLAG = 8'h7E;

  typedef struct packed {
    logic              vld;
    logic [CODE_W-1:0] code;
  } hist_ent_t;
endpackage

// File: rtl/bom_window.sv
module bom_window
  import bom_rx_pkg::*;
#(
  parameter int PRE_LEN  = 8,
  parameter int IDLE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              pat_o,
  output logic [CODE_W-1:0] code_o,
  output logic              flag_o,
  output logic              idle_o
);
  localparam int WIN_W = PRE_LEN + CODE_W + 2;
  localparam int RUN_W = $clog2(IDLE_LEN);

  logic [WIN_W-1:0] win_q, win_nxt;
  logic [RUN_W-1:0] run_q;
  logic             flag_raw;

  assign win_nxt  = {win_q[WIN_W-2:0], bit_i};
  assign code_o   = win_nxt[CODE_W:1];
  assign pat_o    = shift_i && (win_nxt[WIN_W-1 -: PRE_LEN+1] == {{PRE_LEN{1'b1}}, 1'b0})
                    && !win_nxt[0];
  assign flag_raw = (win_nxt[7:0] == HDLC_FLAG);
  // a codeword ending in 0 111111 0 is data, not a flag
  assign flag_o   = shift_i && flag_raw && !pat_o;
  assign idle_o   = shift_i && bit_i && (run_q == RUN_W'(IDLE_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      run_q <= '0;
    end else if (clr_i) begin
      win_q <= '0;
      run_q <= '0;
    end else if (shift_i) begin
      win_q <= win_nxt;
      if (!bit_i || idle_o) run_q <= '0;
      else                  run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/bom_history.sv
module bom_history
  import bom_rx_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cnt_o
);
  // only DEPTH-1 older entries matter once the new code is counted
  localparam int KEEP = DEPTH - 1;

  hist_ent_t       ent_q [KEEP];
  logic [KEEP-1:0] hit;

  for (genvar k = 0; k < KEEP; k++) begin : g_ent
    assign hit[k] = ent_q[k].vld && (ent_q[k].code == code_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q[k] <= '0;
      else if (clr_i)   ent_q[k] <= '0;
      else if (push_i) begin
        if (k == 0) ent_q[k] <= '{vld: 1'b1, code: code_i};
        else        ent_q[k] <= ent_q[(k == 0) ? 0 : k-1];
      end
    end
  end

  always_comb begin
    cnt_o = CNT_W'(1);
    for (int k = 0; k < KEEP; k++) cnt_o = cnt_o + CNT_W'(hit[k]);
  end
endmodule

// File: rtl/bom_outq.sv
module bom_outq
  import bom_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_set_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              filt_set_i,
  input  logic              end_set_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              msg_end_o
);
  logic              code_pend_q, filt_pend_q, end_pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_pend_q <= 1'b0;
      filt_pend_q <= 1'b0;
      end_pend_q  <= 1'b0;
      code_q      <= '0;
    end else begin
      code_pend_q <= code_set_i;
      if (code_set_i) code_q <= code_i;
      filt_pend_q <= filt_set_i | (filt_pend_q & code_pend_q);
      end_pend_q  <= end_set_i | (end_pend_q & (code_pend_q | filt_pend_q));
    end
  end

  always_comb begin
    wr_en_o   = code_pend_q | filt_pend_q | end_pend_q;
    msg_end_o = 1'b0;
    wr_data_o = '0;
    if (code_pend_q)      wr_data_o = DATA_W'(code_q);
    else if (filt_pend_q) wr_data_o = ST_FILTERED;
    else if (end_pend_q) begin
      wr_data_o = ST_FRAME_END;
      msg_end_o = 1'b1;
    end
  end
endmodule

// File: rtl/bom_filter_rx.sv
module bom_filter_rx
  import bom_rx_pkg::*;
#(
  parameter int HIST_DEPTH = 10,
  parameter int ACCEPT_MIN = 7,
  parameter int EXIT_MISS  = 4,
  parameter int EXIT_IDLE  = 4,
  parameter int PRE_LEN    = 8,
  parameter int IDLE_LEN   = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              rx_active_i,
  input  logic              filter_en_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              msg_end_o
);
  localparam int CNT_W  = $clog2(HIST_DEPTH + 1);
  localparam int MISS_W = $clog2(EXIT_MISS);
  localparam int IDLE_W = $clog2(EXIT_IDLE);

  logic              active_q, stop_q;
  logic              shift, deact;
  logic              pat, flag, idle;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;
  logic              filt_run, f_clr, same_acc, exit_miss, exit_idle, accept, push;
  logic              locked_q;
  logic [CODE_W-1:0] acc_q;
  logic [MISS_W-1:0] miss_q;
  logic [IDLE_W-1:0] idle_cnt_q;

  assign shift = active_q && rx_active_i && bit_valid_i;
  assign deact = active_q && !rx_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (!rx_active_i) begin
      active_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (flag) begin
      active_q <= 1'b0;
      stop_q   <= 1'b1;
    end else if (!stop_q) begin
      active_q <= 1'b1;
    end
  end

  bom_window #(.PRE_LEN(PRE_LEN), .IDLE_LEN(IDLE_LEN)) u_win (
    .clk_i, .rst_ni,
    .clr_i  (!active_q),
    .shift_i(shift),
    .bit_i,
    .pat_o  (pat),
    .code_o (code),
    .flag_o (flag),
    .idle_o (idle)
  );

  assign filt_run  = filter_en_i && active_q && rx_active_i;
  assign same_acc  = locked_q && (code == acc_q);
  assign exit_miss = filt_run && pat && locked_q && !same_acc
                     && (miss_q == MISS_W'(EXIT_MISS - 1));
  assign exit_idle = filt_run && idle && (idle_cnt_q == IDLE_W'(EXIT_IDLE - 1));
  assign f_clr     = !filt_run || flag || exit_miss || exit_idle;
  assign push      = filt_run && pat && !exit_miss;
  assign accept    = push && (cnt >= CNT_W'(ACCEPT_MIN)) && !same_acc;

  bom_history #(.DEPTH(HIST_DEPTH), .CNT_W(CNT_W)) u_hist (
    .clk_i, .rst_ni,
    .clr_i (f_clr),
    .push_i(push),
    .code_i(code),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      acc_q      <= '0;
      miss_q     <= '0;
      idle_cnt_q <= '0;
    end else if (f_clr) begin
      locked_q   <= 1'b0;
      miss_q     <= '0;
      idle_cnt_q <= '0;
    end else begin
      if (accept) begin
        locked_q <= 1'b1;
        acc_q    <= code;
        miss_q   <= '0;
      end else if (pat && locked_q) begin
        miss_q <= same_acc ? '0 : miss_q + 1'b1;
      end
      if (pat)       idle_cnt_q <= '0;
      else if (idle) idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

  bom_outq #(.DATA_W(DATA_W)) u_outq (
    .clk_i, .rst_ni,
    .code_set_i(pat && (filter_en_i ? accept : 1'b1)),
    .code_i    (code),
    .filt_set_i(accept),
    .end_set_i (flag || deact),
    .wr_en_o, .wr_data_o, .msg_end_o
  );
endmodule

// File: rtl/bom_filter_rx_chk.sv
module bom_filter_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_i,
  input logic              bit_valid_i,
  input logic              rx_active_i,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              msg_end_o
);
  assert_end_is_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_end_o |-> (wr_en_o && wr_data_o == 8'h40));

  assert_filt_follows_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o == 8'h80) |-> $past(wr_en_o));

  assert_code_after_stop_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[7:6] == 2'b00) |-> ($past(bit_valid_i) && !$past(bit_i)));

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_active_i && !$past(rx_active_i) && !$past(rx_active_i, 2) && !$past(rx_active_i, 3))
      |-> !wr_en_o);

  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |=> (!wr_en_o && !msg_end_o));
endmodule

bind bom_filter_rx bom_filter_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
  .rx_active_i(rx_active_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
  .msg_end_o(msg_end_o)
);

// File: tb/bom_filter_rx_test.sv
module bom_filter_rx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       rx_active_i = 1'b0;
  logic       filter_en_i = 1'b0;
  logic       wr_en_o;
  logic [7:0] wr_data_o;
  logic       msg_end_o;

  int errors = 0;
  int checks = 0;
  bit gaps = 1'b0;
  bit done = 1'b0;
  logic [8:0] got[$];
  logic [8:0] exp_q[$];

  // bench model of the vote (newest first)
  logic [5:0] m_code[10];
  bit         m_vld[10];
  bit         m_lock;
  logic [5:0] m_acc;
  int         m_miss;

  always #10 clk_i = ~clk_i;

  bom_filter_rx uut (.*);

  always @(negedge clk_i)
    if (rst_ni && wr_en_o) got.push_back({msg_end_o, wr_data_o});

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(logic b);
    bit_i = b;
    bit_valid_i = 1'b1;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    if (gaps && ($urandom % 4 == 0)) @(negedge clk_i);
  endtask

  task automatic send_bom(logic [5:0] c);
    logic [15:0] w;
    w = {8'hFF, 1'b0, c, 1'b0};
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_flag();
    logic [7:0] f;
    f = 8'h7E;
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic activate();
    rx_active_i = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic deactivate();
    rx_active_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic compare(string req);
    repeat (5) @(negedge clk_i);
    chk({req, " count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(req, got[i], exp_q[i]);
    got.delete();
    exp_q.delete();
  endtask

  task automatic model_reset();
    for (int i = 0; i < 10; i++) m_vld[i] = 0;
    m_lock = 0;
    m_miss = 0;
  endtask

  task automatic model_pat(logic [5:0] c);
    int n;
    n = 1;
    for (int i = 0; i < 9; i++) if (m_vld[i] && m_code[i] == c) n++;
    if (m_lock && c != m_acc && m_miss == 3) begin
      model_reset();
      return;
    end
    for (int i = 9; i > 0; i--) begin
      m_vld[i] = m_vld[i-1];
      m_code[i] = m_code[i-1];
    end
    m_vld[0] = 1;
    m_code[0] = c;
    if (n >= 7 && !(m_lock && c == m_acc)) begin
      exp_q.push_back({3'b000, c});
      exp_q.push_back(9'h080);
      m_lock = 1;
      m_acc = c;
      m_miss = 0;
    end else if (m_lock) begin
      m_miss = (c == m_acc) ? 0 : m_miss + 1;
    end
  endtask

  initial begin
    logic [5:0] seq[10];
    process_start();
  end

  task automatic process_start();
    logic [5:0] mix[10];
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 wr_en in reset", wr_en_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 wr_en after reset", wr_en_o, 0);
    chk("R10 msg_end after reset", msg_end_o, 0);

    // R1 / R8 direct mode, including the flag-like code 0x3F
    gaps = 1'b1;
    activate();
    send_bom(6'h05); send_bom(6'h2A); send_bom(6'h3F);
    exp_q.push_back(9'h005); exp_q.push_back(9'h02A); exp_q.push_back(9'h03F);
    compare("R1_R8 direct codes");

    // R9 bits without valid are ignored; R7 end on deactivation
    for (int i = 0; i < 16; i++) begin
      bit_i = (i < 8); @(negedge clk_i);
    end
    deactivate();
    exp_q.push_back(9'h140);
    compare("R9_R7 no valid then deactivate");
    send_bom(6'h09);
    compare("R9 inactive bits ignored");

    // R6 flag ends frame and stops sampling
    activate();
    send_bom(6'h11);
    send_flag();
    send_bom(6'h22);
    exp_q.push_back(9'h011); exp_q.push_back(9'h140);
    compare("R6 flag end and stop");
    deactivate();
    compare("R6 no second end after stop");

    // R11 / R2 acceptance followed at once by deactivation
    gaps = 1'b0;
    filter_en_i = 1'b1;
    activate();
    for (int i = 0; i < 7; i++) send_bom(6'h15);
    rx_active_i = 1'b0;
    repeat (4) @(negedge clk_i);
    exp_q.push_back(9'h015); exp_q.push_back(9'h080); exp_q.push_back(9'h140);
    compare("R11_R2 code filt end order");

    // R2 exactly 7 of 10 on the tenth pattern
    gaps = 1'b1;
    activate();
    mix = '{6'h15, 6'h0C, 6'h15, 6'h15, 6'h0C, 6'h15, 6'h15, 6'h0C, 6'h15, 6'h15};
    for (int i = 0; i < 9; i++) send_bom(mix[i]);
    compare("R2 below threshold");
    send_bom(mix[9]);
    exp_q.push_back(9'h015); exp_q.push_back(9'h080);
    compare("R2 seven of ten");

    // R3 repeats of accepted code stay silent
    for (int i = 0; i < 3; i++) send_bom(6'h15);
    compare("R3 no rewrite");

    // R4 four mismatches clear history
    for (int i = 0; i < 4; i++) send_bom(6'h2A);
    for (int i = 0; i < 6; i++) send_bom(6'h15);
    compare("R4 cleared history needs seven");
    send_bom(6'h15);
    exp_q.push_back(9'h015); exp_q.push_back(9'h080);
    compare("R4 reaccept after exit");

    // R5 four idle patterns clear history
    for (int i = 0; i < 64; i++) send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bom(6'h15);
    compare("R5 cleared by idle");
    send_bom(6'h15);
    exp_q.push_back(9'h015); exp_q.push_back(9'h080);
    compare("R5 reaccept after idle");

    // R2/R3/R4 random filtered traffic vs bench model
    deactivate();
    exp_q.push_back(9'h140);
    compare("R7 deactivate in filter mode");
    activate();
    model_reset();
    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      logic [5:0] c;
      int r;
      r = $urandom % 10;
      c = (r < 6) ? 6'h15 : (r < 8) ? 6'h2A : 6'h0C;
      send_bom(c);
      model_pat(c);
    end
    compare("R2_R3_R4 random filtered");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule